// File: doc/BRIEF.md
# Parallel TSP Lower Bound Unit

This block estimates the cheapest possible cost of any salesman tour that extends the current partial solution of a depth-first branch-and-bound search. The search keeps its state in small memories: a degree-one flag per vertex, the far end-point of the path fragment through each open vertex, and a per-vertex adjacency record that lists the cheap edges (weights 0, 1 and 2) with a pruning level for each. The unit scans those records several vertices per clock. For every open vertex it keeps the cheapest edge that could still be used. It adds up these minima, halves the sum rounding upward and adds the cost of the partial solution.

The degree and end-point vectors arrive as flat inputs. The adjacency records are fetched through one synchronous read port per lane. Each dual-port copy of the adjacency memory can serve lanes 2c and 2c+1, so L lanes need ceil(L/2) copies. The caller holds the degree-one vector and the end-point vector stable from the start pulse until the result appears. The caller also sizes `CW` so that the bound does not overflow.

Top module: `tsp_lower_bound`

## Requirements
- R1: After reset `valid`, `busy` and `rd_en` are 0 and `bound` is 0.
- R2: A start pulse accepted at clock edge E0 raises `rd_en` for BEATS = ceil(NV/L) cycles. In beat b, which follows edge E0+b, lane l presents address b*L+l. The record for that address is expected on the lane's `rd_data` slice one clock later.
- R3: `valid` goes high for exactly one cycle, following edge E0+BEATS+2. `busy` stays high from E0 until that same edge.
- R4: Only vertices whose `deg_one` bit is 1 contribute to the sum. Every other vertex contributes 0.
- R5: The contribution of an open vertex v is the lowest weight among its usable slots. A slot is usable when its valid bit is 1, its neighbour is below NV, is not v and has its `deg_one` bit set.
- R6: A slot whose pruning level c is nonzero and c <= the depth captured at start is ignored.
- R7: A slot whose neighbour equals v's path end-point (`other_end` field v, VW bits at bit v*VW) is ignored, unless exactly two vertices have `deg_one` set.
- R8: An open vertex with no usable slot contributes 3.
- R9: `bound` = captured partial cost + ceil(sum / 2), modulo 2^CW.
- R10: Lanes whose address is NV or more in the last beat contribute 0, whatever their read data holds.
- R11: A start pulse while `busy` is high is ignored and does not shift the timing of the running computation.
- R12: `part_cost` and `depth` are captured at the accepted start. Later changes do not affect the result.
- R13: Slot s of a record occupies bits s*SLW and up, with SLW = LW+2+VW+1. Within a slot, from the LSB: pruning level (LW bits), weight (2 bits), neighbour (VW bits), valid (1 bit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a bound computation when idle |
| part_cost | input | CW | Cost of the current partial solution |
| depth | input | LW | Current search depth |
| deg_one | input | NV | Per-vertex degree-one flag |
| other_end | input | NV*VW | Per-vertex path end-point index |
| rd_en | output | 1 | Read strobe for all lane ports |
| rd_addr | output | L*AW | Vertex address per lane |
| rd_data | input | L*K*SLW | Adjacency record per lane, one cycle after the address |
| busy | output | 1 | Computation in progress |
| valid | output | 1 | One-cycle result strobe |
| bound | output | CW | Lower bound result |

## Verification
The bench builds the unit with NV=14, L=4, K=3 slots, LW=3 and CW=8. With these values there are four beats, and the last beat has two lanes past the vertex count. This makes masking visible: the memory model returns cheap edges at addresses 14 and 15. Three slots per vertex are enough to mix usable, pruned and cycle-closing edges in one record. A 3-bit depth allows pruning levels both above and below the current depth. The cases also cover the two-open-vertex tour closure, odd sums that need the upward rounding, and start pulses or input changes made during a run.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [0:0] {ST_IDLE, ST_RUN} tlb_state_e;

  // Edge counted from both ends: halve, rounding up so the bound stays safe.
  function automatic int unsigned halve_up(input int unsigned s);
    return (s + 1) >> 1;
  endfunction

  // A slot pruned at this depth or shallower is not usable.
  function automatic logic edge_hidden(input int unsigned cut, input int unsigned lvl);
    return (cut != 0) && (cut <= lvl);
  endfunction
endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int BEATS = 4,
  parameter int BTW   = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  output logic           take,
  output logic           issue,
  output logic           fin,
  output logic           busy,
  output logic [BTW-1:0] beat
);
  tlb_state_e st;

  assign busy  = (st == ST_RUN);
  assign take  = start && !busy;
  assign issue = busy && (int'(beat) < BEATS);
  assign fin   = busy && (int'(beat) == BEATS + 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      beat <= '0;
    end else if (take) begin
      st   <= ST_RUN;
      beat <= '0;
    end else if (fin) begin
      st   <= ST_IDLE;
    end else if (busy) begin
      beat <= beat + BTW'(1);
    end
  end

  // R11: a start pulse during a run leaves the beat sequence running
  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (!busy || beat == $past(beat) + BTW'(1)));
endmodule

// File: rtl/tlb_lane.sv
module tlb_lane
  import tlb_pkg::*;
#(
  parameter int NV = 14,
  parameter int K  = 3,
  parameter int VW = 4,
  parameter int AW = 4,
  parameter int LW = 3,
  localparam int SLW = LW + 2 + VW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [AW-1:0]    vtx,
  input  logic [K*SLW-1:0] rec,
  input  logic [NV-1:0]    deg_one,
  input  logic [NV*VW-1:0] other_end,
  input  logic             tour_close_ok,
  input  logic [LW-1:0]    lvl,
  output logic [1:0]       contrib
);
  logic          own_open;
  logic [VW-1:0] own_mate;
  logic [K-1:0]  slot_ok;
  logic [1:0]    slot_w [K];
  logic          hit_any;

  // Vertex lookup by comparison: addresses past NV never match (R10).
  always_comb begin
    own_open = 1'b0;
    own_mate = '0;
    for (int i = 0; i < NV; i++) begin
      if (int'(vtx) == i) begin
        own_open = deg_one[i];
        own_mate = other_end[i*VW +: VW];
      end
    end
  end

  for (genvar s = 0; s < K; s++) begin : g_slot
    logic [SLW-1:0] fld;
    logic [VW-1:0]  nbr;
    logic           nb_open;
    assign fld       = rec[s*SLW +: SLW];
    assign nbr       = fld[LW+2 +: VW];
    assign slot_w[s] = fld[LW +: 2];
    always_comb begin
      nb_open = 1'b0;
      for (int i = 0; i < NV; i++)
        if (int'(nbr) == i) nb_open = deg_one[i];
    end
    assign slot_ok[s] = fld[SLW-1] && nb_open
                      && (int'(nbr) != int'(vtx))
                      && !edge_hidden(int'(fld[LW-1:0]), int'(lvl))
                      && !((nbr == own_mate) && !tour_close_ok);
  end

  assign hit_any = |slot_ok;

  always_comb begin
    logic [1:0] best;
    best = 2'd3;
    for (int s = 0; s < K; s++)
      if (slot_ok[s] && slot_w[s] < best) best = slot_w[s];
    contrib = (active && own_open) ? best : 2'd0;
  end

  // R8: an open vertex with no usable slot falls back to weight 3
  assert_default_three_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && own_open && !hit_any) |-> (contrib == 2'd3));
endmodule

// File: rtl/tlb_accum.sv
module tlb_accum #(
  parameter int L  = 4,
  parameter int NV = 14,
  parameter int SW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          add_en,
  input  logic [2*L-1:0] lane_c,
  output logic [SW-1:0] sum
);
  logic [SW-1:0] beat_sum;

  always_comb begin
    beat_sum = '0;
    for (int l = 0; l < L; l++) beat_sum = beat_sum + SW'(lane_c[2*l +: 2]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sum <= '0;
    else if (clear)  sum <= '0;
    else if (add_en) sum <= sum + beat_sum;
  end

  // R9: the running sum never exceeds three per vertex
  assert_sum_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sum) <= 3 * NV);
  // R2: each accepted start begins a fresh sum
  assert_clear_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (sum == '0));
endmodule

// File: rtl/tsp_lower_bound.sv
module tsp_lower_bound
  import tlb_pkg::*;
#(
  parameter int NV = 14,
  parameter int L  = 4,
  parameter int K  = 3,
  parameter int LW = 3,
  parameter int CW = 8,
  localparam int BEATS = (NV + L - 1) / L,
  localparam int AW    = $clog2(BEATS * L),
  localparam int VW    = $clog2(NV),
  localparam int SLW   = LW + 2 + VW + 1,
  localparam int RW    = K * SLW,
  localparam int SW    = $clog2(3 * NV + 1),
  localparam int BTW   = $clog2(BEATS + 2),
  localparam int LTW   = BTW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CW-1:0]    part_cost,
  input  logic [LW-1:0]    depth,
  input  logic [NV-1:0]    deg_one,
  input  logic [NV*VW-1:0] other_end,
  output logic             rd_en,
  output logic [L*AW-1:0]  rd_addr,
  input  logic [L*RW-1:0]  rd_data,
  output logic             busy,
  output logic             valid,
  output logic [CW-1:0]    bound
);
  logic           take, fin, issue, data_live, tour_close_ok;
  logic [BTW-1:0] beat;
  logic [L*AW-1:0] addr_q;
  logic [CW-1:0]  cost_q;
  logic [LW-1:0]  depth_q;
  logic [2*L-1:0] lane_c;
  logic [SW-1:0]  acc_sum;
  logic [LTW-1:0] lat;

  tlb_ctrl #(.BEATS(BEATS), .BTW(BTW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .take(take), .issue(issue),
    .fin(fin), .busy(busy), .beat(beat)
  );

  assign rd_en         = issue;
  assign tour_close_ok = ($countones(deg_one) == 2);

  always_comb begin
    for (int l = 0; l < L; l++)
      rd_addr[l*AW +: AW] = AW'(int'(beat) * L + l);
  end

  for (genvar l = 0; l < L; l++) begin : g_lane
    tlb_lane #(.NV(NV), .K(K), .VW(VW), .AW(AW), .LW(LW)) u_lane (
      .clk(clk), .rst_n(rst_n), .active(data_live),
      .vtx(addr_q[l*AW +: AW]), .rec(rd_data[l*RW +: RW]),
      .deg_one(deg_one), .other_end(other_end),
      .tour_close_ok(tour_close_ok), .lvl(depth_q),
      .contrib(lane_c[2*l +: 2])
    );
  end

  tlb_accum #(.L(L), .NV(NV), .SW(SW)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(take), .add_en(data_live),
    .lane_c(lane_c), .sum(acc_sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_live <= 1'b0;
      addr_q    <= '0;
      cost_q    <= '0;
      depth_q   <= '0;
      valid     <= 1'b0;
      bound     <= '0;
      lat       <= '0;
    end else begin
      data_live <= issue;
      if (issue) addr_q <= rd_addr;
      if (take) begin
        cost_q  <= part_cost;
        depth_q <= depth;
      end
      valid <= fin;
      if (fin) bound <= cost_q + CW'(halve_up(int'(acc_sum)));
      if (take)      lat <= '0;
      else if (busy) lat <= lat + LTW'(1);
    end
  end

  // R3: result strobe lasts one cycle
  assert_valid_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  // R3: result arrives a fixed BEATS+2 cycles after the accepted start
  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (lat == LTW'(BEATS + 2)));
  // R2: reads are issued only while a computation runs
  assert_reads_in_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> busy);
endmodule

// File: tb/sim_tsp_lower_bound.sv
module sim_tsp_lower_bound;
  localparam int NV = 14, L = 4, K = 3, LW = 3, CW = 8;
  localparam int BEATS = 4, AW = 4, VW = 4, SLW = LW + 2 + VW + 1, RW = K * SLW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, rd_en, busy, valid;
  logic [CW-1:0] part_cost = '0, bound;
  logic [LW-1:0] depth = '0;
  logic [NV-1:0] deg_one = '0;
  logic [NV*VW-1:0] other_end = '0;
  logic [L*AW-1:0] rd_addr;
  logic [L*RW-1:0] rd_data;

  tsp_lower_bound #(.NV(NV), .L(L), .K(K), .LW(LW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .part_cost(part_cost), .depth(depth),
    .deg_one(deg_one), .other_end(other_end), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy), .valid(valid), .bound(bound)
  );

  // Reference graph state
  bit sv [NV][K];
  int sn [NV][K], sw [NV][K], sc [NV][K];
  bit dg [NV];
  int oe [NV];
  logic [RW-1:0] mem [16];
  logic [RW-1:0] rdq [L];
  int nchk = 0, nfail = 0;
  bit done = 0;

  always @(posedge clk)
    if (rd_en) for (int l = 0; l < L; l++) rdq[l] <= mem[rd_addr[l*AW +: AW]];
  always_comb for (int l = 0; l < L; l++) rd_data[l*RW +: RW] = rdq[l];

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R13 slot layout from LSB: cut, weight, neighbour, valid
  task automatic pack();
    for (int v = 0; v < 16; v++) begin
      logic [RW-1:0] r;
      r = '0;
      for (int s = 0; s < K; s++) begin
        if (v < NV)
          r[s*SLW +: SLW] = {sv[v][s], VW'(sn[v][s]), 2'(sw[v][s]), LW'(sc[v][s])};
        else  // R10 trap: cheap edge into vertex 1
          r[s*SLW +: SLW] = {1'b1, VW'(1), 2'd0, LW'(0)};
      end
      mem[v] = r;
    end
    for (int v = 0; v < NV; v++) begin
      deg_one[v] = dg[v];
      other_end[v*VW +: VW] = VW'(oe[v]);
    end
  endtask

  task automatic clear_graph();
    for (int v = 0; v < NV; v++) begin
      dg[v] = 0; oe[v] = v;
      for (int s = 0; s < K; s++) begin sv[v][s] = 0; sn[v][s] = 0; sw[v][s] = 0; sc[v][s] = 0; end
    end
  endtask

  function automatic int ref_bound(int pc, int dp);
    int ones = 0, total = 0;
    for (int v = 0; v < NV; v++) ones += dg[v];
    for (int v = 0; v < NV; v++) begin
      if (dg[v]) begin
        int m = 3;
        for (int s = 0; s < K; s++) begin
          int n = sn[v][s];
          if (!sv[v][s] || n >= NV || n == v) continue;
          if (!dg[n]) continue;
          if (sc[v][s] != 0 && sc[v][s] <= dp) continue;
          if (oe[v] == n && ones != 2) continue;
          if (sw[v][s] < m) m = sw[v][s];
        end
        total += m;
      end
    end
    return (pc + (total + 1) / 2) % 256;
  endfunction

  task automatic run_case(string tag, int pc, int dp, bit poke_start);
    int exp;
    exp = ref_bound(pc, dp);
    pack();
    @(negedge clk);
    part_cost = CW'(pc); depth = LW'(dp); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k <= BEATS + 3; k++) begin
      if (k < BEATS) begin
        chk(rd_en === 1'b1, {tag, " R2 rd_en"}, int'(rd_en), 1);
        for (int l = 0; l < L; l++)
          chk(int'(rd_addr[l*AW +: AW]) == k * L + l, {tag, " R2 addr"},
              int'(rd_addr[l*AW +: AW]), k * L + l);
      end else chk(rd_en === 1'b0, {tag, " R2 rd_en low"}, int'(rd_en), 0);
      chk(valid === (k == BEATS + 2), {tag, " R3 valid"}, int'(valid), int'(k == BEATS + 2));
      chk(busy === (k < BEATS + 2), {tag, " R3 busy"}, int'(busy), int'(k < BEATS + 2));
      if (k == BEATS + 2) chk(int'(bound) == exp, {tag, " bound"}, int'(bound), exp);
      if (k == 1) begin  // R12 disturb captured inputs; R11 optional start
        part_cost = CW'(pc ^ 8'h55); depth = LW'(~dp);
        if (poke_start) start = 1'b1;
      end
      if (k == 2) start = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    clear_graph();
    pack();
    repeat (3) @(negedge clk);
    chk(valid === 1'b0, "R1 valid", int'(valid), 0);
    chk(busy === 1'b0, "R1 busy", int'(busy), 0);
    chk(rd_en === 1'b0, "R1 rd_en", int'(rd_en), 0);
    chk(bound === '0, "R1 bound", int'(bound), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 R10: all open, paired fragments, mixed weights
    for (int v = 0; v < NV; v++) begin
      dg[v] = 1; oe[v] = v ^ 1;
      for (int s = 0; s < K; s++) begin
        sv[v][s] = 1; sn[v][s] = (v + 1 + 3 * s) % NV; sw[v][s] = (v + s) % 3; sc[v][s] = 0;
      end
    end
    run_case("R5 R10 mixed", 10, 0, 0);

    // R4 R11: some vertices closed, start poked mid-run
    for (int v = 0; v < NV; v++) dg[v] = (v % 3 != 0);
    run_case("R4 R11 closed", 33, 0, 1);

    // R6: pruning levels 0..3 against depth 2 and depth 0
    for (int v = 0; v < NV; v++) begin
      dg[v] = 1;
      for (int s = 0; s < K; s++) sc[v][s] = (v + s) % 4;
    end
    run_case("R6 depth2", 7, 2, 0);
    run_case("R6 depth0", 7, 0, 0);
    run_case("R6 depth7", 7, 7, 0);

    // R7 R9: two open vertices on one fragment, closing allowed, odd sum
    clear_graph();
    dg[3] = 1; dg[9] = 1; oe[3] = 9; oe[9] = 3;
    sv[3][0] = 1; sn[3][0] = 9; sw[3][0] = 0;
    sv[9][0] = 1; sn[9][0] = 3; sw[9][0] = 1;
    run_case("R7 R9 close", 100, 0, 0);

    // R7 R8: four open vertices, premature cycle hidden, defaults of 3
    dg[5] = 1; dg[6] = 1; oe[5] = 6; oe[6] = 5;
    run_case("R7 R8 premature", 0, 0, 0);

    // R8 R9: no usable slots anywhere
    clear_graph();
    for (int v = 0; v < NV; v++) dg[v] = 1;
    run_case("R8 R9 empty", 200, 0, 0);

    // R9 wrap of the cost field
    run_case("R9 wrap", 250, 0, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule